// File: doc/BRIEF.md
# Dual-Clock FIFO with Programmable Threshold Flags

This block is a first-in first-out buffer for 9-bit words whose depth is a power-of-two parameter. Words enter on the write clock and leave on an independent read clock, and the two clocks may be fully unrelated. The read side presents each word from a register that loads only on an accepted read. Four active-low flags report occupancy. Empty and near-empty belong to the read clock. Full and near-full belong to the write clock.

The near-empty and near-full thresholds come from two offset registers. These are loaded through the write data bus and read back through the read data bus. The second write-enable pin is sampled while reset is held and selects one of two modes for the rest of operation. In the gated mode, that pin is a second write enable. In the load mode, driving it low turns write and read accesses into offset-register accesses, which step through a fixed four-slot sequence.

Pointers cross between the clock domains as Gray code through two-stage synchronizers. Each domain therefore counts its own operations at once, and sees the other side's progress a few of its own clock edges later.

Top module: `dc_fifo_pflags`

## Requirements
- R1: While `rst_n` is low, `full_n` and `near_full_n` are 1, `empty_n` and `near_empty_n` are 0, both pointers return to slot 0, both offsets return to 7, the output register clears to zero and the offset sequencers return to slot 0.
- R2: If `wr_en_b_ld` is 1 during reset, the block is in gated mode. A word is written on a `wr_clk` rising edge only when `wr_en_a_n` is 0 and `wr_en_b_ld` is 1.
- R3: If `wr_en_b_ld` is 0 during reset, the block is in load mode. A word is written when `wr_en_a_n` is 0 and `wr_en_b_ld` is 1. When `wr_en_a_n` is 0 and `wr_en_b_ld` is 0, `wr_data[7:0]` goes into the next offset slot instead and no FIFO word is written. The slots are visited in the order 0 (empty offset bits 7:0), 1 (empty offset bits 15:8), 2 (full offset bits 7:0), 3 (full offset bits 15:8), then back to 0.
- R4: Words leave in the order they were accepted, with no loss and no duplication.
- R5: The output register loads on a `rd_clk` rising edge only when both `rd_en_a_n` and `rd_en_b_n` are 0. Otherwise it holds its value.
- R6: A write request is ignored while `full_n` is 0. A read request is ignored while `empty_n` is 0.
- R7: With depth D, empty offset n and full offset m:
  - At 0 words, `empty_n` and `near_empty_n` are 0.
  - At 1 to n words, only `near_empty_n` is 0.
  - At n+1 to D-m-1 words, all flags are 1.
  - At D-m to D-1 words, only `near_full_n` is 0.
  - At D words, `full_n` and `near_full_n` are 0.
- R8: After reset, with no offsets loaded, both offsets equal 7. For D=256 this means `near_empty_n` rises at 8 words and `near_full_n` falls at 249 words.
- R9: In load mode, with `wr_en_b_ld` at 0 and both read enables at 0, a `rd_clk` edge loads the output register with {1'b0, the current slot's byte} and advances the read-side slot in the same order as R3. No FIFO word is consumed.
- R10: When no reads are pending, `full_n` and `near_full_n` fall at the `wr_clk` edge of the write that reaches their threshold.
- R11: While `out_en_n` is 1, `rd_data` is 0 and `rd_data_vld` is 0. While `out_en_n` is 0, `rd_data` shows the output register and `rd_data_vld` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Write-side clock |
| rd_clk | input | 1 | Read-side clock |
| rst_n | input | 1 | Active-low reset; mode is sampled while low |
| wr_data | input | DW (9) | Write data; bits 7:0 also carry offset bytes |
| wr_en_a_n | input | 1 | Active-low primary write enable |
| wr_en_b_ld | input | 1 | Second write enable (gated mode) or active-low load control (load mode) |
| rd_en_a_n | input | 1 | Active-low read enable A |
| rd_en_b_n | input | 1 | Active-low read enable B |
| out_en_n | input | 1 | Active-low output enable |
| rd_data | output | DW (9) | Read data, zero while disabled |
| rd_data_vld | output | 1 | High while the read data is driven |
| empty_n | output | 1 | Low when no words are stored (read domain) |
| full_n | output | 1 | Low when D words are stored (write domain) |
| near_empty_n | output | 1 | Low at or below n words (read domain) |
| near_full_n | output | 1 | Low at or above D-m words (write domain) |

## Verification
The main function is tried with three patterns. A short gated-mode burst with one blocked write tells a correct second enable apart from one that is ignored. A single-enable read shows whether the output register wrongly advances. A fill to full and a drain back to empty cover every boundary of the flag table under the default offsets, the overflow block at full and the underflow hold at empty. A load-mode run writes custom offsets, reads them back with the wrap to slot 0, and interleaves FIFO traffic. This run tells whether offset accesses leak into the data path and whether the thresholds really follow the loaded values.

// File: rtl/dc_fifo_pflags.sv
module pflag_seq #(
  parameter int W = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         step,
  output logic [W-1:0] idx
);
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)    idx <= '0;
    else if (step) idx <= idx + 1'b1;
endmodule

module dc_fifo_pflags #(
  parameter int DW    = 9,
  parameter int DEPTH = 256,
  parameter int OFS0  = 7
) (
  input  logic          wr_clk,
  input  logic          rd_clk,
  input  logic          rst_n,
  input  logic [DW-1:0] wr_data,
  input  logic          wr_en_a_n,
  input  logic          wr_en_b_ld,
  input  logic          rd_en_a_n,
  input  logic          rd_en_b_n,
  input  logic          out_en_n,
  output logic [DW-1:0] rd_data,
  output logic          rd_data_vld,
  output logic          empty_n,
  output logic          full_n,
  output logic          near_empty_n,
  output logic          near_full_n
);
  localparam int AW = $clog2(DEPTH);
  localparam int PW = AW + 1;

  function automatic logic [PW-1:0] to_gray(input logic [PW-1:0] b);
    return b ^ (b >> 1);
  endfunction

  function automatic logic [PW-1:0] from_gray(input logic [PW-1:0] g);
    logic [PW-1:0] b;
    b[PW-1] = g[PW-1];
    for (int i = PW - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction

  logic [DW-1:0] mem [DEPTH];
  logic [PW-1:0] wbin, rbin, wgray, rgray;
  logic [PW-1:0] wg_s1, wg_s2, rg_s1, rg_s2;
  logic          wmode_ld, rmode_ld;
  logic [15:0]   ofs_e, ofs_f;
  logic [1:0]    widx, ridx;
  logic [DW-1:0] q_reg;

  always_ff @(posedge wr_clk) if (!rst_n) wmode_ld <= !wr_en_b_ld;
  always_ff @(posedge rd_clk) if (!rst_n) rmode_ld <= !wr_en_b_ld;

  // write domain
  logic          wr_go, ofs_wr;
  logic [PW-1:0] wbin_nx, rbin_w, wcnt_nx;
  logic [AW+1:0] nf_sum;

  assign wr_go   = !wr_en_a_n && wr_en_b_ld && full_n;
  assign ofs_wr  = wmode_ld && !wr_en_a_n && !wr_en_b_ld;
  assign wbin_nx = wbin + {{AW{1'b0}}, wr_go};
  assign rbin_w  = from_gray(rg_s2);
  assign wcnt_nx = wbin_nx - rbin_w;
  assign nf_sum  = {1'b0, wcnt_nx} + {2'b0, ofs_f[AW-1:0]};

  pflag_seq #(.W(2)) u_wseq (.clk(wr_clk), .rst_n(rst_n), .step(ofs_wr), .idx(widx));

  always_ff @(posedge wr_clk) if (wr_go) mem[wbin[AW-1:0]] <= wr_data;

  always_ff @(posedge wr_clk or negedge rst_n)
    if (!rst_n) begin
      wbin        <= '0;
      wgray       <= '0;
      full_n      <= 1'b1;
      near_full_n <= 1'b1;
      rg_s1       <= '0;
      rg_s2       <= '0;
    end else begin
      wbin        <= wbin_nx;
      wgray       <= to_gray(wbin_nx);
      full_n      <= !(wcnt_nx == PW'(DEPTH));
      near_full_n <= !(nf_sum >= (AW+2)'(DEPTH));
      rg_s1       <= rgray;
      rg_s2       <= rg_s1;
    end

  always_ff @(posedge wr_clk or negedge rst_n)
    if (!rst_n) begin
      ofs_e <= 16'(OFS0);
      ofs_f <= 16'(OFS0);
    end else if (ofs_wr) begin
      case (widx)
        2'd0: ofs_e[7:0]  <= wr_data[7:0];
        2'd1: ofs_e[15:8] <= wr_data[7:0];
        2'd2: ofs_f[7:0]  <= wr_data[7:0];
        default: ofs_f[15:8] <= wr_data[7:0];
      endcase
    end

  // read domain
  logic          rd_req, rd_go, ofs_rd;
  logic [PW-1:0] rbin_nx, wbin_r, rcnt_nx;
  logic [7:0]    ofs_byte;

  assign rd_req  = !rd_en_a_n && !rd_en_b_n;
  assign ofs_rd  = rmode_ld && !wr_en_b_ld && rd_req;
  assign rd_go   = rd_req && empty_n && !(rmode_ld && !wr_en_b_ld);
  assign rbin_nx = rbin + {{AW{1'b0}}, rd_go};
  assign wbin_r  = from_gray(wg_s2);
  assign rcnt_nx = wbin_r - rbin_nx;

  always_comb
    case (ridx)
      2'd0:    ofs_byte = ofs_e[7:0];
      2'd1:    ofs_byte = ofs_e[15:8];
      2'd2:    ofs_byte = ofs_f[7:0];
      default: ofs_byte = ofs_f[15:8];
    endcase

  pflag_seq #(.W(2)) u_rseq (.clk(rd_clk), .rst_n(rst_n), .step(ofs_rd), .idx(ridx));

  always_ff @(posedge rd_clk or negedge rst_n)
    if (!rst_n) begin
      rbin         <= '0;
      rgray        <= '0;
      empty_n      <= 1'b0;
      near_empty_n <= 1'b0;
      wg_s1        <= '0;
      wg_s2        <= '0;
      q_reg        <= '0;
    end else begin
      rbin         <= rbin_nx;
      rgray        <= to_gray(rbin_nx);
      empty_n      <= (rcnt_nx != '0);
      near_empty_n <= (rcnt_nx > {1'b0, ofs_e[AW-1:0]});
      wg_s1        <= wgray;
      wg_s2        <= wg_s1;
      if (rd_go)       q_reg <= mem[rbin[AW-1:0]];
      else if (ofs_rd) q_reg <= {{(DW-8){1'b0}}, ofs_byte};
    end

  assign rd_data     = out_en_n ? '0 : q_reg;
  assign rd_data_vld = !out_en_n;
endmodule

// File: rtl/dc_fifo_pflags_chk.sv
module dc_fifo_pflags_chk #(
  parameter int DW = 9,
  parameter int PW = 9
) (
  input logic          wr_clk,
  input logic          rd_clk,
  input logic          rst_n,
  input logic          full_n,
  input logic          near_full_n,
  input logic          empty_n,
  input logic          near_empty_n,
  input logic          rd_en_a_n,
  input logic          rd_en_b_n,
  input logic          out_en_n,
  input logic [DW-1:0] rd_data,
  input logic [PW-1:0] wptr,
  input logic [PW-1:0] rptr
);
  always @(negedge wr_clk)
    if (!rst_n) AST_RST_WR_FLAGS: assert (full_n && near_full_n); // R1

  always @(negedge rd_clk)
    if (!rst_n) AST_RST_RD_FLAGS: assert (!empty_n && !near_empty_n); // R1

  AST_FULL_IMPLIES_NEAR: assert property (@(posedge wr_clk) disable iff (!rst_n)
    !full_n |-> !near_full_n); // R7

  AST_EMPTY_IMPLIES_NEAR: assert property (@(posedge rd_clk) disable iff (!rst_n)
    !empty_n |-> !near_empty_n); // R7

  AST_NO_OVERFLOW: assert property (@(posedge wr_clk) disable iff (!rst_n)
    !full_n |=> $stable(wptr)); // R6

  AST_NO_UNDERFLOW: assert property (@(posedge rd_clk) disable iff (!rst_n)
    !empty_n |=> $stable(rptr)); // R6

  AST_WPTR_STEP: assert property (@(posedge wr_clk) disable iff (!rst_n)
    (wptr == $past(wptr)) || (wptr == $past(wptr) + 1'b1)); // R4

  AST_OUT_HOLD: assert property (@(posedge rd_clk) disable iff (!rst_n)
    (!out_en_n && $past(!out_en_n) && $past(rd_en_a_n || rd_en_b_n)) |-> $stable(rd_data)); // R5
endmodule

bind dc_fifo_pflags dc_fifo_pflags_chk #(.DW(DW), .PW(PW)) u_chk (
  .wr_clk(wr_clk), .rd_clk(rd_clk), .rst_n(rst_n),
  .full_n(full_n), .near_full_n(near_full_n),
  .empty_n(empty_n), .near_empty_n(near_empty_n),
  .rd_en_a_n(rd_en_a_n), .rd_en_b_n(rd_en_b_n), .out_en_n(out_en_n),
  .rd_data(rd_data), .wptr(wbin), .rptr(rbin)
);

// File: tb/dc_fifo_pflags_bench.sv
`timescale 1ns/1ps
module dc_fifo_pflags_bench;
  localparam int DW = 9;
  localparam int D  = 256;

  logic wr_clk = 0, rd_clk = 0, rst_n = 0;
  logic [DW-1:0] wr_data = '0;
  logic wr_en_a_n = 1, wr_en_b_ld = 1, rd_en_a_n = 1, rd_en_b_n = 1, out_en_n = 0;
  logic [DW-1:0] rd_data;
  logic rd_data_vld, empty_n, full_n, near_empty_n, near_full_n;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #5   wr_clk = ~wr_clk;
  always #6.5 rd_clk = ~rd_clk;

  dc_fifo_pflags #(.DW(DW), .DEPTH(D)) u_dc_fifo_pflags (
    .wr_clk(wr_clk), .rd_clk(rd_clk), .rst_n(rst_n), .wr_data(wr_data),
    .wr_en_a_n(wr_en_a_n), .wr_en_b_ld(wr_en_b_ld), .rd_en_a_n(rd_en_a_n),
    .rd_en_b_n(rd_en_b_n), .out_en_n(out_en_n), .rd_data(rd_data),
    .rd_data_vld(rd_data_vld), .empty_n(empty_n), .full_n(full_n),
    .near_empty_n(near_empty_n), .near_full_n(near_full_n)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] pat(input int k);
    return DW'(k * 37 + 5);
  endfunction

  task automatic do_reset(input bit ld_mode);
    @(negedge wr_clk);
    rst_n = 0; wr_en_b_ld = !ld_mode; wr_en_a_n = 1;
    repeat (4) @(negedge rd_clk);
    repeat (4) @(negedge wr_clk);
    rst_n = 1;
    @(negedge wr_clk);
    wr_en_b_ld = 1;
    @(negedge rd_clk);
    chk("R1 empty_n", empty_n, 0);
    chk("R1 near_empty_n", near_empty_n, 0);
    chk("R1 full_n", full_n, 1);
    chk("R1 near_full_n", near_full_n, 1);
    chk("R1 rd_data", rd_data, 0);
  endtask

  task automatic settle();
    repeat (8) @(negedge rd_clk);
    repeat (8) @(negedge wr_clk);
  endtask

  task automatic wr_word(input logic [DW-1:0] v, input logic b);
    @(negedge wr_clk);
    wr_data = v; wr_en_a_n = 0; wr_en_b_ld = b;
    @(negedge wr_clk);
    wr_en_a_n = 1; wr_en_b_ld = 1;
  endtask

  task automatic wr_ofs(input logic [7:0] v);
    @(negedge wr_clk);
    wr_data = {1'b0, v}; wr_en_a_n = 0; wr_en_b_ld = 0;
    @(negedge wr_clk);
    wr_en_a_n = 1; wr_en_b_ld = 1;
  endtask

  task automatic rd_word(output logic [DW-1:0] v);
    @(negedge rd_clk);
    rd_en_a_n = 0; rd_en_b_n = 0;
    @(negedge rd_clk);
    v = rd_data; rd_en_a_n = 1; rd_en_b_n = 1;
  endtask

  task automatic rd_back(input int exp, input string tag);
    @(negedge rd_clk);
    wr_en_b_ld = 0; rd_en_a_n = 0; rd_en_b_n = 0;
    @(negedge rd_clk);
    chk(tag, rd_data, exp);
    rd_en_a_n = 1; rd_en_b_n = 1; wr_en_b_ld = 1;
  endtask

  task automatic t_gated();
    logic [DW-1:0] v;
    do_reset(0);
    wr_word(9'h101, 1);
    wr_word(9'h0FF, 0);
    wr_word(9'h055, 1);
    settle();
    rd_word(v); chk("R2/R4 first word", v, 9'h101);
    @(negedge rd_clk); rd_en_a_n = 0; rd_en_b_n = 1;
    @(negedge rd_clk); rd_en_a_n = 1;
    chk("R5 hold on single enable", rd_data, 9'h101);
    rd_word(v); chk("R2 blocked word skipped", v, 9'h055);
    chk("R6 empty after last read", empty_n, 0);
    rd_word(v); chk("R6 read on empty ignored", v, 9'h055);
    @(negedge rd_clk); out_en_n = 1;
    #1 chk("R11 data off", rd_data, 0);
    chk("R11 valid off", rd_data_vld, 0);
    out_en_n = 0;
    #1 chk("R11 data back", rd_data, 9'h055);
  endtask

  task automatic t_fill_drain();
    logic [DW-1:0] v;
    int bad;
    do_reset(0);
    for (int k = 0; k < 7; k++) wr_word(pat(k), 1);
    settle();
    chk("R7 empty_n at n words", empty_n, 1);
    chk("R7 near_empty_n at n words", near_empty_n, 0);
    wr_word(pat(7), 1);
    settle();
    chk("R8 near_empty_n at 8 words", near_empty_n, 1);
    for (int k = 8; k < 248; k++) wr_word(pat(k), 1);
    chk("R7 near_full_n at D-m-1", near_full_n, 1);
    wr_word(pat(248), 1);
    chk("R10 near_full_n at 249 words", near_full_n, 0);
    for (int k = 249; k < 255; k++) wr_word(pat(k), 1);
    chk("R7 full_n at D-1", full_n, 1);
    wr_word(pat(255), 1);
    chk("R10 full_n at D words", full_n, 0);
    wr_word(9'h1FF, 1);
    chk("R6 full stays on blocked write", full_n, 0);
    bad = 0;
    for (int k = 0; k < D; k++) begin
      rd_word(v);
      if (v !== pat(k)) bad++;
    end
    chk("R4 order over full depth", bad, 0);
    chk("R6 no extra word after full", empty_n, 0);
    rd_word(v); chk("R6 hold on empty", v, pat(255));
    settle();
    chk("R7 full_n released", full_n, 1);
    chk("R7 near_full_n released", near_full_n, 1);
  endtask

  task automatic t_load_mode();
    logic [DW-1:0] v;
    do_reset(1);
    wr_ofs(8'd3); wr_ofs(8'd0); wr_ofs(8'd10); wr_ofs(8'd0);
    settle();
    chk("R3 offset writes are not words", empty_n, 0);
    for (int k = 0; k < 3; k++) wr_word(pat(k), 1);
    settle();
    rd_back(3,  "R9 slot0");
    rd_back(0,  "R9 slot1");
    rd_back(10, "R9 slot2");
    rd_back(0,  "R9 slot3");
    rd_back(3,  "R9 wrap to slot0");
    chk("R7 near_empty_n with n=3 at 3 words", near_empty_n, 0);
    rd_word(v); chk("R9 readback consumed nothing", v, pat(0));
    wr_word(pat(3), 1);
    settle();
    chk("R3 near_empty_n at 3 words", near_empty_n, 0);
    wr_word(pat(4), 1);
    settle();
    chk("R3 near_empty_n at 4 words", near_empty_n, 1);
    for (int k = 5; k < 246; k++) wr_word(pat(k), 1);
    chk("R7 near_full_n at 245 with m=10", near_full_n, 1);
    wr_word(pat(246), 1);
    chk("R3 near_full_n at 246 with m=10", near_full_n, 0);
  endtask

  initial begin
    t_gated();
    t_fill_drain();
    t_load_mode();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    #1_500_000;
    if (!done) begin
      done = 1;
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule